// File: doc/BRIEF.md
# Data-Strobe Serial Deserializer with Sync Code Decoding

This block turns a serial image link carried on a data line and a strobe line into bytes on a parallel bus. Both lines arrive as logic levels. The block samples them with its own system clock. Every change in the XOR of data and strobe marks one bit, and the value of that bit is the current data level. Bits are packed into bytes with the least significant bit first.

A 32-bit sliding window watches the bit stream for synchronization codes. A code is the byte sequence 0xFF, 0x00, 0x00 followed by a type byte. A frame-start code is recognised on any bit boundary, and it sets the byte phase. All other codes are recognised only on that locked byte phase. The codes drive a frame sync output and a line sync output. The line-level codes are replaced by frame-level codes at the start and end of each frame.

A mode input selects what appears on the parallel bus. In one mode every received byte appears, code bytes included. In the other mode the code bytes are removed. An enable input forces both sync outputs low without losing the tracked frame and line state. Each byte appears on the bus once the three bytes that follow it have arrived.

Top module: `dsr_link_rx`

## Requirements
- R1: After reset, `pix_valid`, `vsync` and `hsync` are low. The link is taken as idle with data high and strobe low. No bit is recovered until the XOR of the two lines changes.
- R2: Each change of `ser_data` XOR `ser_strobe` yields exactly one bit. The bit value is the `ser_data` level after the change.
- R3: Bits are assembled into bytes least significant bit first. Bit 0 of each byte is the earliest bit received.
- R4: Before the first frame-start code has been received, no byte is presented on `pix_valid`/`pix_data`.
- R5: A sync code is 0xFF, 0x00, 0x00 followed by a type byte. The type values are 0x00 line start, 0x01 line end, 0x02 frame start and 0x03 frame end. A sequence whose type byte is any other value is ordinary data and is never removed.
- R6: With `sync_strip` low, every byte from the first frame-start code onward is presented once, in arrival order, code bytes included. A byte is presented when the third byte after it completes.
- R7: With `sync_strip` high, the four bytes of every recognised sync code are withheld. Every other byte is presented in arrival order.
- R8: A frame-start code sets `vsync` and `hsync` high. A frame-end code sets both low. A line-start code sets `hsync` high. A line-end code sets `hsync` low.
- R9: A line-start code received outside a frame (after frame end, before the next frame start) leaves `hsync` low.
- R10: While `sync_enable` is low, `vsync` and `hsync` are low one cycle later. The frame and line state is kept, and it reappears on the outputs when `sync_enable` returns high.
- R11: A frame-start code that arrives on a different bit phase re-aligns the byte phase. Bytes from that code onward are presented correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line, logic level |
| ser_strobe | input | 1 | Serial strobe line, logic level |
| sync_strip | input | 1 | High: withhold sync code bytes from the parallel bus |
| sync_enable | input | 1 | Low: force `vsync` and `hsync` low |
| pix_data | output | BYTE_W | Parallel byte output |
| pix_valid | output | 1 | One-cycle strobe marking a byte on `pix_data` |
| vsync | output | 1 | Frame sync, high inside a frame |
| hsync | output | 1 | Line sync, high inside a line |

## Verification
Several properties are checked on every cycle:
- The enable gating of both sync outputs.
- The rule that line sync implies frame sync.
- The rule that a byte strobe can only follow a recovered bit.
- The rule that a sync output can only change on a code event or an enable change.

The bench scenarios are needed for the rest:
- The byte values themselves and their LSB-first order.
- Alignment on an arbitrary bit phase.
- The treatment of a look-alike sequence with an unknown type byte.
- Re-alignment on a shifted frame start.
- The exact set of bytes withheld in strip mode.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int CODE_LEN = 4;

  typedef enum logic [1:0] {
    CODE_LS = 2'd0,
    CODE_LE = 2'd1,
    CODE_FS = 2'd2,
    CODE_FE = 2'd3
  } code_t;
endpackage

// File: rtl/dsr_bit_recover.sv
module dsr_bit_recover (
  input  logic clk,
  input  logic rst,
  input  logic ser_data,
  input  logic ser_strobe,
  output logic bit_stb,
  output logic bit_val
);
  logic d_q, s_q, x_q;

  // Idle: data high, strobe low, so the reference XOR starts at 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      d_q     <= 1'b1;
      s_q     <= 1'b0;
      x_q     <= 1'b1;
      bit_stb <= 1'b0;
      bit_val <= 1'b1;
    end else begin
      d_q     <= ser_data;
      s_q     <= ser_strobe;
      x_q     <= d_q ^ s_q;
      bit_stb <= (d_q ^ s_q) ^ x_q;
      bit_val <= d_q;
    end
  end
endmodule

// File: rtl/dsr_byte_framer.sv
module dsr_byte_framer
  import dsr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              strip,
  output logic [BYTE_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              code_ev,
  output code_t             code_kind
);
  localparam int WIN_W = BYTE_W * CODE_LEN;
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int SKP_W = $clog2(CODE_LEN);
  localparam logic [3*BYTE_W-1:0] PREFIX = {{(2*BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [WIN_W-1:0]  win_q, win_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [SKP_W-1:0]  skip_q;
  logic              lock_q;
  logic [BYTE_W-1:0] type_byte;
  logic              code_hit, fs_hit, boundary;

  // Newest bit enters at the top; the oldest byte sits in the low bits.
  always_comb begin
    win_nx    = {bit_val, win_q[WIN_W-1:1]};
    type_byte = win_nx[WIN_W-1 -: BYTE_W];
    code_hit  = (win_nx[3*BYTE_W-1:0] == PREFIX) && (type_byte[BYTE_W-1:2] == '0);
    fs_hit    = code_hit && (type_byte[1:0] == CODE_FS);
    boundary  = fs_hit || (lock_q && (cnt_q == CNT_W'(BYTE_W - 1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= '0;
      cnt_q     <= '0;
      skip_q    <= '0;
      lock_q    <= 1'b0;
      pix_data  <= '0;
      pix_valid <= 1'b0;
      code_ev   <= 1'b0;
      code_kind <= CODE_LS;
    end else begin
      pix_valid <= 1'b0;
      code_ev   <= 1'b0;
      if (bit_stb) begin
        win_q <= win_nx;
        if (boundary) begin
          cnt_q    <= '0;
          lock_q   <= 1'b1;
          pix_data <= win_nx[BYTE_W-1:0];
          if (code_hit) begin
            code_ev   <= 1'b1;
            code_kind <= code_t'(type_byte[1:0]);
            skip_q    <= SKP_W'(CODE_LEN - 1);
            pix_valid <= !strip;
          end else begin
            pix_valid <= !(strip && (skip_q != '0));
            if (skip_q != '0) skip_q <= skip_q - SKP_W'(1);
          end
        end else if (lock_q) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dsr_sync_track.sv
module dsr_sync_track
  import dsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  code_ev,
  input  code_t code_kind,
  input  logic  enable,
  output logic  vsync,
  output logic  hsync
);
  logic frame_q, line_q, frame_nx, line_nx;

  always_comb begin
    frame_nx = frame_q;
    line_nx  = line_q;
    if (code_ev) begin
      unique case (code_kind)
        CODE_FS: begin frame_nx = 1'b1; line_nx = 1'b1; end
        CODE_FE: begin frame_nx = 1'b0; line_nx = 1'b0; end
        CODE_LS: line_nx = frame_q;
        CODE_LE: line_nx = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      line_q  <= 1'b0;
      vsync   <= 1'b0;
      hsync   <= 1'b0;
    end else begin
      frame_q <= frame_nx;
      line_q  <= line_nx;
      vsync   <= enable & frame_nx;
      hsync   <= enable & line_nx;
    end
  end
endmodule

// File: rtl/dsr_link_rx.sv
module dsr_link_rx
  import dsr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  input  logic              ser_strobe,
  input  logic              sync_strip,
  input  logic              sync_enable,
  output logic [BYTE_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              vsync,
  output logic              hsync
);
  logic  bit_stb, bit_val, code_ev;
  code_t code_kind;

  dsr_bit_recover u_rec (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  dsr_byte_framer #(.BYTE_W(BYTE_W)) u_frm (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val), .strip(sync_strip),
    .pix_data(pix_data), .pix_valid(pix_valid), .code_ev(code_ev), .code_kind(code_kind)
  );

  dsr_sync_track u_trk (
    .clk(clk), .rst(rst), .code_ev(code_ev), .code_kind(code_kind),
    .enable(sync_enable), .vsync(vsync), .hsync(hsync)
  );
endmodule

// File: rtl/dsr_link_rx_chk.sv
module dsr_link_rx_chk (
  input logic clk,
  input logic rst,
  input logic sync_enable,
  input logic vsync,
  input logic hsync,
  input logic pix_valid,
  input logic bit_stb,
  input logic code_ev
);
  assert_sync_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(sync_enable) |-> (!vsync && !hsync));

  // Line sync is only ever set inside a frame.
  assert_line_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    hsync |-> vsync);

  // A byte strobe follows a recovered bit.
  assert_byte_after_bit_R2: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(bit_stb));

  assert_hsync_fall_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync) |-> (!$past(sync_enable) || $past(code_ev)));

  assert_vsync_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> ($past(sync_enable) && ($past(code_ev) || !$past(sync_enable, 2))));
endmodule

bind dsr_link_rx dsr_link_rx_chk u_chk (
  .clk(clk), .rst(rst), .sync_enable(sync_enable), .vsync(vsync), .hsync(hsync),
  .pix_valid(pix_valid), .bit_stb(bit_stb), .code_ev(code_ev)
);

// File: tb/sim_dsr_link_rx.sv
module sim_dsr_link_rx;
  localparam int CPB = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_data = 1'b1, ser_strobe = 1'b0;
  logic       sync_strip = 1'b0, sync_enable = 1'b1;
  logic [7:0] pix_data;
  logic       pix_valid, vsync, hsync;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic d_cur = 1'b1, s_cur = 1'b0;
  logic [7:0] got_q[$];
  logic [7:0] seg_q[$];
  bit         flg_q[$];

  always #4 clk = ~clk;

  dsr_link_rx u0 (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .sync_strip(sync_strip), .sync_enable(sync_enable),
    .pix_data(pix_data), .pix_valid(pix_valid), .vsync(vsync), .hsync(hsync)
  );

  always @(negedge clk) if (!rst && pix_valid) got_q.push_back(pix_data);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd_pay();
    return 8'($urandom_range(1, 126));
  endfunction

  task automatic send_bit(input logic b);
    if (b == d_cur) s_cur = ~s_cur;
    d_cur = b;
    @(negedge clk);
    ser_data = d_cur;
    ser_strobe = s_cur;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit is_code);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    seg_q.push_back(v);
    flg_q.push_back(is_code);
  endtask

  task automatic send_code(input logic [7:0] t);
    send_byte(8'hFF, 1'b1); send_byte(8'h00, 1'b1);
    send_byte(8'h00, 1'b1); send_byte(t, 1'b1);
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    d_cur = 1'b1; s_cur = 1'b0;
    ser_data = 1'b1; ser_strobe = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    got_q.delete();
    @(negedge clk);
  endtask

  // Expected byte list: all segment bytes but the last three, codes withheld in strip mode.
  task automatic build_exp(input bit strip, output logic [7:0] e[$]);
    e.delete();
    for (int i = 0; i + 3 < seg_q.size(); i++)
      if (!(strip && flg_q[i])) e.push_back(seg_q[i]);
  endtask

  task automatic run_frame(input bit strip, input int offset, input bit realign);
    logic [7:0] e[$];
    int base, n;
    string tag;
    sync_strip = strip;
    if (!realign) begin
      do_reset();
      chk("R1 pix_valid", 32'(pix_valid), 0);
      chk("R1 vsync", 32'(vsync), 0);
      chk("R1 hsync", 32'(hsync), 0);
      for (int i = 0; i < 3; i++) send_byte(rnd_pay(), 1'b0);
      repeat (6) @(negedge clk);
      chk("R4 no bytes before frame start", 32'(got_q.size()), 0);
    end
    base = got_q.size();
    seg_q.delete(); flg_q.delete();
    for (int i = 0; i < offset; i++) send_bit(1'b0);
    send_code(8'h02);
    chk("R8 vsync after FS", 32'(vsync), 1);
    chk("R8 hsync after FS", 32'(hsync), 1);
    n = $urandom_range(4, 9);
    for (int i = 0; i < n; i++) send_byte(rnd_pay(), 1'b0);
    send_code(8'h01);
    chk("R8 hsync after LE", 32'(hsync), 0);
    chk("R8 vsync after LE", 32'(vsync), 1);
    // Look-alike with an unknown type byte: plain data (R5).
    send_byte(8'hFF, 1'b0); send_byte(8'h00, 1'b0);
    send_byte(8'h00, 1'b0); send_byte(8'h07, 1'b0);
    repeat (6) @(negedge clk);
    chk("R5 unknown type keeps hsync low", 32'(hsync), 0);
    send_code(8'h00);
    chk("R8 hsync after LS", 32'(hsync), 1);
    n = $urandom_range(3, 8);
    for (int i = 0; i < n; i++) send_byte(rnd_pay(), 1'b0);
    @(negedge clk); sync_enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 vsync gated", 32'(vsync), 0);
    chk("R10 hsync gated", 32'(hsync), 0);
    sync_enable = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 vsync restored", 32'(vsync), 1);
    chk("R10 hsync restored", 32'(hsync), 1);
    send_code(8'h03);
    chk("R8 vsync after FE", 32'(vsync), 0);
    chk("R8 hsync after FE", 32'(hsync), 0);
    send_code(8'h00);
    chk("R9 LS outside frame", 32'(hsync), 0);
    for (int i = 0; i < 3; i++) send_byte(rnd_pay(), 1'b0);
    repeat (8) @(negedge clk);
    build_exp(strip, e);
    tag = realign ? "R11 realigned byte" : (strip ? "R2 R3 R5 R7 byte" : "R2 R3 R5 R6 byte");
    if (!realign) chk({tag, " count"}, 32'(got_q.size() - base), 32'(e.size()));
    if (got_q.size() >= e.size()) begin
      for (int i = 0; i < e.size(); i++)
        chk(tag, 32'(got_q[got_q.size() - e.size() + i]), 32'(e[i]));
    end else begin
      chk({tag, " too few"}, 32'(got_q.size()), 32'(e.size()));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    do_reset();
    // R1: idle lines after reset yield nothing.
    repeat (20) @(negedge clk);
    chk("R1 idle no bytes", 32'(got_q.size()), 0);
    run_frame(1'b0, $urandom_range(0, 7), 1'b0);
    run_frame(1'b1, $urandom_range(0, 7), 1'b0);
    run_frame(1'b1, 0, 1'b0);
    run_frame(1'b0, $urandom_range(1, 7), 1'b1);
    run_frame(1'b1, 5, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule